// File: doc/BRIEF.md
# Edge-Aligned Radio Bit Serializer

This block connects an 8-bit host to the data pin of a simple on-off-keyed radio. On transmit it waits a host-set number of idle bit periods, sends a host-set start pattern, and then shifts host bytes onto the pin, most significant bit first. Every bit lasts a fixed number of clock ticks. The host hands over one byte at a time through a single holding register.

On receive, an outside start-symbol detector pulses `rx_start`. The block then watches the synchronized radio input. The first level change it sees is stamped with a free-running fine counter, and that same change sets the phase of the bit sampler. Bits are taken in the middle of each bit period, packed most significant bit first, and offered to the host a byte at a time with a ready flag. The host never handles single bits.

With the default 4 MHz clock and `BIT_TICKS` = 80, one bit is 20 us (50 kb/s) and a timestamp resolves to 0.25 us.

Top module: `radio_bit_serdes`

## Requirements
- R1: `rx_edge_ts` takes the value of a counter that starts at 0 on the first clock edge after reset and rises by one per clock. The value taken is the one at the clock edge where the first level change after `rx_start` appears at the output of the 2-flop input synchronizer. That edge is 2 clocks after the change at the `radio_rx` pin. The value then holds until the next alignment.
- R2: The first bit is sampled BIT_TICKS/2 clocks after the aligning edge, and each later bit BIT_TICKS clocks after the one before it. Level changes after alignment do not move the sampling phase.
- R3: Bits are packed most significant bit first. On the eighth bit, `rx_data` shows the byte and `rx_ready` is set.
- R4: A one-clock `rx_ack` clears `rx_ready`. If a byte completes in the same clock, `rx_ready` stays set.
- R5: If a byte completes while `rx_ready` is set and not being acknowledged, `rx_overrun` is set and the new byte replaces the old one. `rx_overrun` stays set until the next `rx_start`.
- R6: `rx_stop` ends reception. No further byte is delivered until the next `rx_start` and alignment.
- R7: A `tx_go` accepted while idle starts a transmission in this order: `cfg_delay` bit periods with the line low, then the SYM_W bits of `cfg_sym` (most significant bit first), then data bytes (most significant bit first). Each bit period is BIT_TICKS clocks. `radio_tx` is low whenever the transmitter is idle.
- R8: `tx_empty` is high when the holding register is free. A `tx_load` is accepted only then, and a `tx_load` while `tx_empty` is low is ignored (the byte sent is the one held).
- R9: A byte loaded with `tx_last` = 1 ends the transmission after its eighth bit, and `tx_busy` then falls.
- R10: If a byte boundary arrives with no byte held, `tx_underrun` is set and the transmission stops. The next accepted `tx_go` clears `tx_underrun`.
- R11: A `tx_go` while `tx_busy` is high is ignored. It changes neither the delay count nor the start pattern in progress.
- R12: With `cfg_delay` = 0, the first start-pattern bit is on the line in the clock right after `tx_go` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timestamp tick |
| rst_n | input | 1 | Active-low synchronous reset |
| radio_rx | input | 1 | Radio receive data pin (idle low) |
| rx_start | input | 1 | Pulse: start-symbol found, arm alignment |
| rx_stop | input | 1 | Pulse: end reception |
| rx_ack | input | 1 | Pulse: host has read `rx_data` |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | Received byte waiting for host |
| rx_overrun | output | 1 | Sticky: byte lost to a slow host |
| rx_edge_ts | output | TS_W | Timestamp of the aligning edge |
| radio_tx | output | 1 | Radio transmit data pin |
| tx_go | input | 1 | Pulse: begin a transmission |
| cfg_delay | input | DLY_W | Idle bit periods before the start pattern |
| cfg_sym | input | SYM_W | Start pattern, sent most significant bit first |
| tx_data | input | 8 | Byte to transmit |
| tx_last | input | 1 | Marks `tx_data` as the final byte |
| tx_load | input | 1 | Pulse: write `tx_data` into the holding register |
| tx_empty | output | 1 | Holding register free (byte request) |
| tx_busy | output | 1 | Transmission in progress |
| tx_underrun | output | 1 | Sticky: host missed a byte boundary |

## Verification
The hardest case to reach from the ports is a received byte that completes in exactly the clock where the host acknowledges the previous one, or one clock on either side. This decides whether `rx_ready` survives and whether `rx_overrun` fires. The bench feeds four bytes back to back. It acknowledges the first two only after watching `rx_ready` rise and leaves the rest unserviced. A clock-by-clock behavioural model scores every cycle, so each ack/completion alignment that arises is checked. On the transmit side, a second `tx_go` arrives in the middle of the delay phase, and a byte boundary is left unfed on purpose.

// File: rtl/radio_serdes_pkg.sv
package radio_serdes_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_DELAY = 2'd1,
    TX_SYM   = 2'd2,
    TX_DATA  = 2'd3
  } tx_state_t;

  // Clocks from the aligning edge to the first bit sample (mid-bit).
  function automatic int unsigned mid_ticks(input int unsigned bit_ticks);
    return bit_ticks / 2;
  endfunction

  // Append one received bit to a shift value, most significant bit first.
  function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic b);
    return {cur[6:0], b};
  endfunction

endpackage

// File: rtl/rx_edge_stamp.sv
module rx_edge_stamp #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            radio_rx,
  output logic            rx_level,
  output logic            edge_seen,
  output logic [TS_W-1:0] ts_now
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
      ts_now <= '0;
    end else begin
      meta_q <= radio_rx;
      sync_q <= meta_q;
      prev_q <= sync_q;
      ts_now <= ts_now + 1'b1;
    end
  end

  assign rx_level  = sync_q;
  assign edge_seen = sync_q ^ prev_q;

endmodule

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
  import radio_serdes_pkg::*;
#(
  parameter int BIT_TICKS = 80,
  parameter int TS_W      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_level,
  input  logic            edge_seen,
  input  logic [TS_W-1:0] ts_now,
  input  logic            rx_start,
  input  logic            rx_stop,
  input  logic            rx_ack,
  output logic [7:0]      rx_data,
  output logic            rx_ready,
  output logic            rx_overrun,
  output logic [TS_W-1:0] rx_edge_ts
);
  localparam int CW = $clog2(BIT_TICKS);
  localparam logic [CW-1:0] FIRST_WAIT = CW'(mid_ticks(BIT_TICKS) - 1);
  localparam logic [CW-1:0] PERIOD_M1  = CW'(BIT_TICKS - 1);

  logic          armed, active;
  logic [CW-1:0] wait_cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    shreg;

  // Named internal events.
  logic       align_now, sample_now, byte_done;
  logic [7:0] packed_byte;

  assign align_now   = armed & edge_seen & ~rx_start & ~rx_stop;
  assign sample_now  = active & ~rx_start & ~rx_stop & (wait_cnt == '0);
  assign byte_done   = sample_now & (bit_idx == 3'd7);
  assign packed_byte = shift_in(shreg, rx_level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      active     <= 1'b0;
      wait_cnt   <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      rx_data    <= '0;
      rx_ready   <= 1'b0;
      rx_overrun <= 1'b0;
      rx_edge_ts <= '0;
    end else begin
      if (rx_start) begin
        armed      <= 1'b1;
        active     <= 1'b0;
        bit_idx    <= '0;
        rx_overrun <= 1'b0;
      end else if (rx_stop) begin
        armed  <= 1'b0;
        active <= 1'b0;
      end else if (align_now) begin
        rx_edge_ts <= ts_now;
        armed      <= 1'b0;
        active     <= 1'b1;
        wait_cnt   <= FIRST_WAIT;
        bit_idx    <= '0;
      end else if (active) begin
        if (sample_now) begin
          wait_cnt <= PERIOD_M1;
          shreg    <= packed_byte;
          bit_idx  <= bit_idx + 1'b1;
        end else begin
          wait_cnt <= wait_cnt - 1'b1;
        end
      end

      if (byte_done) begin
        rx_data  <= packed_byte;
        rx_ready <= 1'b1;
        if (rx_ready && !rx_ack) rx_overrun <= 1'b1;
      end else if (rx_ack) begin
        rx_ready <= 1'b0;
      end
    end
  end

  AST_ONE_MODE:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0({armed, active}));              // R2
  AST_TS_HELD:   assert property (@(posedge clk) disable iff (!rst_n) !align_now |=> $stable(rx_edge_ts));      // R1
  AST_RDY_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) rx_ready && !rx_ack |=> rx_ready);        // R4
  AST_RDY_DROP:  assert property (@(posedge clk) disable iff (!rst_n) rx_ack && !byte_done |=> !rx_ready);      // R4
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                   $rose(rx_overrun) |-> $past(byte_done && rx_ready && !rx_ack));                               // R5
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) rx_stop |=> !byte_done);                  // R6

endmodule

// File: rtl/tx_bit_sender.sv
module tx_bit_sender
  import radio_serdes_pkg::*;
#(
  parameter int BIT_TICKS = 80,
  parameter int SYM_W     = 8,
  parameter int DLY_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_go,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [SYM_W-1:0] cfg_sym,
  input  logic [7:0]       tx_data,
  input  logic             tx_last,
  input  logic             tx_load,
  output logic             radio_tx,
  output logic             tx_empty,
  output logic             tx_busy,
  output logic             tx_underrun
);
  localparam int CW  = $clog2(BIT_TICKS);
  localparam int BCW = $clog2(SYM_W > 8 ? SYM_W : 8) + 1;
  localparam logic [CW-1:0]  PERIOD_M1 = CW'(BIT_TICKS - 1);
  localparam logic [BCW-1:0] SYM_LAST  = BCW'(SYM_W - 1);
  localparam logic [BCW-1:0] BYTE_LAST = BCW'(7);

  tx_state_t        state;
  logic [CW-1:0]    tick_cnt;
  logic [DLY_W-1:0] delay_left;
  logic [BCW-1:0]   bit_idx;
  logic [SYM_W-1:0] sym_sh;
  logic [7:0]       data_sh;
  logic             cur_last;
  logic [7:0]       hold;
  logic             hold_last, hold_full;

  // Named internal events.
  logic go_ok, bit_tick, take, fetch, finish;

  assign go_ok    = tx_go && (state == TX_IDLE);
  assign bit_tick = (state != TX_IDLE) && (tick_cnt == PERIOD_M1);
  assign take     = tx_load && !hold_full;
  assign fetch    = bit_tick && (((state == TX_SYM) && (bit_idx == SYM_LAST)) ||
                                 ((state == TX_DATA) && (bit_idx == BYTE_LAST) && !cur_last));
  assign finish   = bit_tick && (state == TX_DATA) && (bit_idx == BYTE_LAST) && cur_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= TX_IDLE;
      tick_cnt    <= '0;
      delay_left  <= '0;
      bit_idx     <= '0;
      sym_sh      <= '0;
      data_sh     <= '0;
      cur_last    <= 1'b0;
      tx_underrun <= 1'b0;
    end else if (go_ok) begin
      tx_underrun <= 1'b0;
      sym_sh      <= cfg_sym;
      delay_left  <= cfg_delay;
      tick_cnt    <= '0;
      bit_idx     <= '0;
      state       <= (cfg_delay == '0) ? TX_SYM : TX_DELAY;
    end else if (state != TX_IDLE) begin
      tick_cnt <= bit_tick ? '0 : tick_cnt + 1'b1;
      if (bit_tick) begin
        case (state)
          TX_DELAY: begin
            delay_left <= delay_left - 1'b1;
            if (delay_left == DLY_W'(1)) state <= TX_SYM;
          end
          TX_SYM: begin
            sym_sh <= sym_sh << 1;
            if (!fetch) bit_idx <= bit_idx + 1'b1;
          end
          TX_DATA: begin
            data_sh <= data_sh << 1;
            if (!fetch && !finish) bit_idx <= bit_idx + 1'b1;
          end
          default: ;
        endcase
      end
      if (fetch) begin
        if (hold_full) begin
          data_sh  <= hold;
          cur_last <= hold_last;
          bit_idx  <= '0;
          state    <= TX_DATA;
        end else begin
          tx_underrun <= 1'b1;
          state       <= TX_IDLE;
        end
      end
      if (finish) state <= TX_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_last <= 1'b0;
      hold_full <= 1'b0;
    end else begin
      if (fetch && hold_full) hold_full <= 1'b0;
      if (take) begin
        hold      <= tx_data;
        hold_last <= tx_last;
        hold_full <= 1'b1;
      end
    end
  end

  always_comb begin
    case (state)
      TX_SYM:  radio_tx = sym_sh[SYM_W-1];
      TX_DATA: radio_tx = data_sh[7];
      default: radio_tx = 1'b0;
    endcase
  end

  assign tx_empty = !hold_full;
  assign tx_busy  = (state != TX_IDLE);

  AST_TICK_GAP:    assert property (@(posedge clk) disable iff (!rst_n) bit_tick |=> !bit_tick);                 // R7
  AST_LOAD_TAKEN:  assert property (@(posedge clk) disable iff (!rst_n) tx_load && tx_empty |=> !tx_empty);      // R8
  AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) tx_load && !tx_empty |=> $stable(hold)); // R8
  AST_UND_CAUSE:   assert property (@(posedge clk) disable iff (!rst_n)
                     $rose(tx_underrun) |-> $past(fetch && tx_empty));                                         // R10
  AST_GO_BUSY:     assert property (@(posedge clk) disable iff (!rst_n)
                     tx_go && tx_busy && !bit_tick |=> tx_busy && $stable(delay_left) && $stable(sym_sh));      // R11

endmodule

// File: rtl/radio_bit_serdes.sv
module radio_bit_serdes #(
  parameter int BIT_TICKS = 80,
  parameter int TS_W      = 16,
  parameter int SYM_W     = 8,
  parameter int DLY_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             radio_rx,
  input  logic             rx_start,
  input  logic             rx_stop,
  input  logic             rx_ack,
  output logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             rx_overrun,
  output logic [TS_W-1:0]  rx_edge_ts,
  output logic             radio_tx,
  input  logic             tx_go,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [SYM_W-1:0] cfg_sym,
  input  logic [7:0]       tx_data,
  input  logic             tx_last,
  input  logic             tx_load,
  output logic             tx_empty,
  output logic             tx_busy,
  output logic             tx_underrun
);
  logic            rx_level, edge_seen;
  logic [TS_W-1:0] ts_now;

  rx_edge_stamp #(.TS_W(TS_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .radio_rx(radio_rx),
    .rx_level(rx_level), .edge_seen(edge_seen), .ts_now(ts_now)
  );

  rx_bit_sampler #(.BIT_TICKS(BIT_TICKS), .TS_W(TS_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .edge_seen(edge_seen),
    .ts_now(ts_now), .rx_start(rx_start), .rx_stop(rx_stop), .rx_ack(rx_ack),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .rx_edge_ts(rx_edge_ts)
  );

  tx_bit_sender #(.BIT_TICKS(BIT_TICKS), .SYM_W(SYM_W), .DLY_W(DLY_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .cfg_delay(cfg_delay),
    .cfg_sym(cfg_sym), .tx_data(tx_data), .tx_last(tx_last), .tx_load(tx_load),
    .radio_tx(radio_tx), .tx_empty(tx_empty), .tx_busy(tx_busy),
    .tx_underrun(tx_underrun)
  );

endmodule

// File: tb/test_radio_bit_serdes.sv
module test_radio_bit_serdes;
  localparam int CLK_PERIOD = 10;
  localparam int BITT = 80;
  localparam int HALF = BITT / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic radio_rx = 0, rx_start = 0, rx_stop = 0, rx_ack = 0;
  logic [7:0] rx_data;
  logic rx_ready, rx_overrun;
  logic [15:0] rx_edge_ts;
  logic radio_tx, tx_go = 0, tx_last = 0, tx_load = 0;
  logic [7:0] cfg_delay = 0, cfg_sym = 0, tx_data = 0;
  logic tx_empty, tx_busy, tx_underrun;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_bit_serdes #(.BIT_TICKS(BITT)) i_radio_bit_serdes (
    .clk(clk), .rst_n(rst_n), .radio_rx(radio_rx), .rx_start(rx_start),
    .rx_stop(rx_stop), .rx_ack(rx_ack), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_overrun(rx_overrun), .rx_edge_ts(rx_edge_ts), .radio_tx(radio_tx),
    .tx_go(tx_go), .cfg_delay(cfg_delay), .cfg_sym(cfg_sym), .tx_data(tx_data),
    .tx_last(tx_last), .tx_load(tx_load), .tx_empty(tx_empty), .tx_busy(tx_busy),
    .tx_underrun(tx_underrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cyc, m_m, m_s, m_d, m_ts, m_armed, m_active, m_wait, m_nb, m_shv, m_rdata, m_rdy, m_ovr;
  int m_st, m_t, m_dc, m_bc, m_sym, m_sh, m_last, m_hold, m_hlast, m_hfull, m_und;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_m = 0; m_s = 0; m_d = 0; m_ts = 0; m_armed = 0; m_active = 0;
      m_wait = 0; m_nb = 0; m_shv = 0; m_rdata = 0; m_rdy = 0; m_ovr = 0;
      m_st = 0; m_t = 0; m_dc = 0; m_bc = 0; m_sym = 0; m_sh = 0; m_last = 0;
      m_hold = 0; m_hlast = 0; m_hfull = 0; m_und = 0;
    end else begin
      int e, smp, done, ld, tick, fetch;
      e = (m_s != m_d); smp = m_s; done = 0;
      if (rx_start) begin m_armed = 1; m_active = 0; m_nb = 0; m_ovr = 0; end
      else if (rx_stop) begin m_armed = 0; m_active = 0; end
      else if (m_armed && e) begin
        m_ts = m_cyc; m_armed = 0; m_active = 1; m_wait = HALF - 1; m_nb = 0;
      end else if (m_active) begin
        if (m_wait == 0) begin
          m_shv = ((m_shv << 1) | smp) & 255; m_wait = BITT - 1;
          if (m_nb == 7) begin done = 1; m_nb = 0; end else m_nb++;
        end else m_wait--;
      end
      if (done) begin
        if (m_rdy && !rx_ack) m_ovr = 1;
        m_rdata = m_shv; m_rdy = 1;
      end else if (rx_ack) m_rdy = 0;
      m_d = m_s; m_s = m_m; m_m = radio_rx;
      m_cyc = (m_cyc + 1) & 16'hFFFF;

      ld = tx_load && !m_hfull; tick = (m_st != 0) && (m_t == BITT - 1); fetch = 0;
      if (tx_go && m_st == 0) begin
        m_und = 0; m_sym = cfg_sym; m_dc = cfg_delay; m_t = 0; m_bc = 0;
        m_st = (cfg_delay == 0) ? 2 : 1;
      end else if (m_st != 0) begin
        m_t = tick ? 0 : m_t + 1;
        if (tick) begin
          case (m_st)
            1: begin m_dc--; if (m_dc == 0) m_st = 2; end
            2: begin m_sym = (m_sym << 1) & 255; if (m_bc == 7) fetch = 1; else m_bc++; end
            default: begin
              m_sh = (m_sh << 1) & 255;
              if (m_bc == 7) begin if (m_last) m_st = 0; else fetch = 1; end else m_bc++;
            end
          endcase
        end
        if (fetch) begin
          if (m_hfull) begin m_sh = m_hold; m_last = m_hlast; m_bc = 0; m_st = 3; m_hfull = 0; end
          else begin m_und = 1; m_st = 0; end
        end
      end
      if (ld) begin m_hold = tx_data; m_hlast = tx_last; m_hfull = 1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int etx;
      etx = (m_st == 2) ? ((m_sym >> 7) & 1) : (m_st == 3) ? ((m_sh >> 7) & 1) : 0;
      chk(radio_tx == etx[0],             "R7 radio_tx",   radio_tx, etx);
      chk(tx_empty == !m_hfull,           "R8 tx_empty",   tx_empty, !m_hfull);
      chk(tx_busy == (m_st != 0),         "R9 tx_busy",    tx_busy, m_st != 0);
      chk(tx_underrun == m_und[0],        "R10 underrun",  tx_underrun, m_und);
      chk(rx_ready == m_rdy[0],           "R3 rx_ready",   rx_ready, m_rdy);
      chk(rx_data == m_rdata[7:0],        "R3 rx_data",    rx_data, m_rdata);
      chk(rx_overrun == m_ovr[0],         "R5 overrun",    rx_overrun, m_ovr);
      chk(rx_edge_ts == m_ts[15:0],       "R1 R2 edge_ts", rx_edge_ts, m_ts);
    end
  end

  // ---------------- stimulus ----------------
  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      radio_rx = b[i];
      nclk(BITT);
    end
  endtask

  task automatic load(input logic [7:0] d, input logic last);
    tx_data = d; tx_last = last; tx_load = 1; nclk(1); tx_load = 0;
  endtask

  task automatic go(input logic [7:0] dly, input logic [7:0] sym);
    cfg_delay = dly; cfg_sym = sym; tx_go = 1; nclk(1); tx_go = 0;
  endtask

  initial begin
    int c;
    logic [15:0] got;
    nclk(5);
    rst_n = 1;
    nclk(1);
    chk(rx_ready == 0 && rx_overrun == 0, "R3 reset rx", rx_ready, 0);
    chk(tx_empty == 1 && tx_busy == 0 && radio_tx == 0, "R8 reset tx", tx_empty, 1);

    // R1 R2 R3 R4 R5: four bytes, first two acknowledged, then overrun
    rx_start = 1; nclk(1); rx_start = 0; nclk(5);
    c = m_cyc;
    fork
      begin send_rx(8'hA5); send_rx(8'h3C); send_rx(8'h0F); send_rx(8'hE1); end
      begin
        repeat (2) begin
          while (!rx_ready) nclk(1);
          rx_ack = 1; nclk(1); rx_ack = 0;
          chk(rx_ready == 0, "R4 ack clears", rx_ready, 0);
        end
      end
    join
    chk(rx_edge_ts == 16'(c + 2), "R1 edge stamp", rx_edge_ts, c + 2);
    chk(rx_overrun == 1, "R5 overrun set", rx_overrun, 1);
    chk(rx_data == 8'hE1, "R5 newest byte kept", rx_data, 8'hE1);

    // R6: stop, then traffic must not deliver a byte
    rx_stop = 1; nclk(1); rx_stop = 0;
    rx_ack = 1; nclk(1); rx_ack = 0;
    radio_rx = 0; nclk(BITT);
    send_rx(8'hFF); send_rx(8'h5A);
    chk(rx_ready == 0, "R6 no byte after stop", rx_ready, 0);

    // R2 R5: new alignment at a different phase, overrun cleared by start
    radio_rx = 0; nclk(37);
    rx_start = 1; nclk(1); rx_start = 0;
    chk(rx_overrun == 0, "R5 cleared by start", rx_overrun, 0);
    nclk(3);
    send_rx(8'h96);
    nclk(1);
    chk(rx_ready == 1 && rx_data == 8'h96, "R2 R3 realigned byte", rx_data, 8'h96);
    rx_ack = 1; nclk(1); rx_ack = 0;
    rx_stop = 1; nclk(1); rx_stop = 0;

    // R7 R8 R9 R11: delayed frame, load while full, go while busy
    load(8'h5A, 0);
    chk(tx_empty == 0, "R8 load taken", tx_empty, 0);
    load(8'hFF, 1);
    go(8'd2, 8'hB2);
    nclk(BITT);
    go(8'd0, 8'h00);
    while (!tx_empty) nclk(1);
    load(8'hC3, 1);
    while (tx_busy) nclk(1);
    chk(tx_underrun == 0, "R9 clean end", tx_underrun, 0);

    // R12 R7: zero delay, decode the line at mid-bit
    load(8'h69, 1);
    cfg_delay = 0; cfg_sym = 8'h2D; tx_go = 1; nclk(1); tx_go = 0;
    chk(radio_tx == 1'b0 && tx_busy == 1, "R12 first sym bit now", radio_tx, 0);
    nclk(HALF);
    for (int k = 0; k < 16; k++) begin
      got = {got[14:0], radio_tx};
      nclk(BITT);
    end
    chk(got == 16'h2D69, "R12 R7 line pattern", got, 16'h2D69);
    while (tx_busy) nclk(1);

    // R10: underrun, then cleared by the next go
    load(8'h81, 0);
    go(8'd1, 8'h55);
    while (tx_busy) nclk(1);
    chk(tx_underrun == 1, "R10 underrun set", tx_underrun, 1);
    chk(radio_tx == 0, "R7 idle low", radio_tx, 0);
    go(8'd3, 8'hF0);
    chk(tx_underrun == 0, "R10 cleared by go", tx_underrun, 0);
    while (tx_busy) nclk(1);
    chk(tx_underrun == 1, "R10 no byte held", tx_underrun, 1);

    nclk(4);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule